// File: doc/BRIEF.md
# Receive Buffer Credit and Backpressure Tracker

This block counts, for each pair of DMA channels, how many empty receive buffers software has handed to the hardware. Software returns buffers by writing a count into a per-pair allocation register. It can also load the count outright by setting the force bit of that register. Each time the receive engine finishes filling a buffer for a pair, it pulses that pair's consume input, and the count drops by one.

The count is compared with a programmable low mark and a programmable high mark. Backpressure toward the packet source rises when the count falls below the low mark. It clears only once the count has climbed back to the high mark, which gives hysteresis. Software usually sets the marks at one third and two thirds of the ring size. Backpressure is produced only while both the global enable bit and the pair's own enable bit in the configuration register are set.

Registers use a plain write strobe and a combinational read port. Each register is decoded from a byte address: the configuration register sits at 0x00, and each pair p has a block of three registers starting at 0x04 + 0x0c·p.

Top module: `flowc_credit_tracker`

## Requirements
- R1: After reset every credit count, low mark and high mark reads 0, the configuration register reads only its channel-count field, and every backpressure output is 0.
- R2: For pair p, the low mark is at byte address 0x04+0x0c·p, the high mark at 0x08+0x0c·p and the allocation register at 0x0c+0x0c·p. The marks hold the low CREDIT_W bits of a write and read back zero-extended. A read of the allocation register returns the pair's credit count.
- R3: In the configuration register at address 0x00, bit 0 is the global enable and bit p+1 is the enable of pair p. Both are writable. Bits 27:24 always read 2·N_PAIRS, and writes to them are ignored.
- R4: A write to an allocation register with bit 31 clear adds its low CREDIT_W bits to the count. The sum saturates at 2^CREDIT_W−1.
- R5: A write to an allocation register with bit 31 set loads the count from its low CREDIT_W bits instead of adding.
- R6: A consume pulse lowers the pair's count by one, and the count never goes below zero. When an add and a consume occur in the same cycle, the count changes by the net amount. When a forced load occurs in the same cycle as a consume, the load wins.
- R7: While the pair is enabled, its backpressure is 1 after any edge at which the new count is below the low mark. It changes on the same edge as the count.
- R8: While the pair is enabled, its backpressure is 0 after any edge at which the new count is at or above the high mark and not below the low mark. Between the marks, backpressure keeps its previous value.
- R9: After any edge at which the global enable or the pair's enable was clear, that pair's backpressure is 0.
- R10: A write to an address that maps to no register (beyond the last pair, or not word aligned) changes nothing, and reading such an address returns 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | ADDR_W | Byte address of the write |
| wr_data | input | 32 | Write data |
| rd_addr | input | ADDR_W | Byte address of the read |
| rd_data | output | 32 | Read data, combinational from rd_addr |
| consume | input | N_PAIRS | One pulse per buffer filled, one bit per pair |
| backpressure | output | N_PAIRS | Flow-control request, one bit per pair |

## Verification
The embedded properties assume that the write and consume inputs are stable across each rising edge. They also assume a consume pulse is only ever a single-cycle event. They do not assume the low mark is below the high mark. If the marks are inverted, the falling-below rule takes priority, and the properties are written with that in mind. The bench drives every input just after a falling edge. It keeps each pair's marks ordered during the random sweep, and it uses forced loads to push counts across both marks and to both saturation ends.

// File: rtl/flowc_pkg.sv
package flowc_pkg;

    // Register targeted by a decoded byte address.
    typedef enum logic [2:0] {
        SEL_NONE  = 3'd0,
        SEL_CFG   = 3'd1,
        SEL_LOW   = 3'd2,
        SEL_HIGH  = 3'd3,
        SEL_ALLOC = 3'd4
    } reg_sel_e;

    localparam int unsigned PAIR_BASE   = 4;
    localparam int unsigned PAIR_STRIDE = 12;
    localparam int unsigned FORCE_BIT   = 31;
    localparam int unsigned COUNT_LSB   = 24;

endpackage

// File: rtl/flowc_decode.sv
module flowc_decode
    import flowc_pkg::*;
#(
    parameter int unsigned N_PAIRS = 4,
    parameter int unsigned ADDR_W  = 8,
    localparam int unsigned PAIR_W = (N_PAIRS > 1) ? $clog2(N_PAIRS) : 1
) (
    input  logic [ADDR_W-1:0] addr,
    output reg_sel_e          sel,
    output logic [PAIR_W-1:0] pair
);

    int unsigned offset;
    int unsigned index;
    int unsigned slot;

    always_comb begin
        sel    = SEL_NONE;
        pair   = '0;
        offset = 0;
        index  = 0;
        slot   = 0;
        if (addr == '0) begin
            sel = SEL_CFG;
        end else if (addr[1:0] == 2'b00 && int'(addr) >= PAIR_BASE) begin
            offset = int'(addr) - PAIR_BASE;
            index  = offset / PAIR_STRIDE;
            slot   = offset % PAIR_STRIDE;
            if (index < N_PAIRS) begin
                pair = PAIR_W'(index);
                case (slot)
                    0:       sel = SEL_LOW;
                    4:       sel = SEL_HIGH;
                    8:       sel = SEL_ALLOC;
                    default: sel = SEL_NONE;
                endcase
            end
        end
    end

endmodule

// File: rtl/flowc_pair.sv
module flowc_pair
    import flowc_pkg::*;
#(
    parameter int unsigned CREDIT_W = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                enable,
    input  logic                wr_low,
    input  logic                wr_high,
    input  logic                wr_alloc,
    input  logic [31:0]         wr_data,
    input  logic                consume,
    output logic [CREDIT_W-1:0] low_mark,
    output logic [CREDIT_W-1:0] high_mark,
    output logic [CREDIT_W-1:0] credit,
    output logic                bp
);

    localparam logic [CREDIT_W-1:0] CREDIT_MAX = '1;

    typedef struct packed {
        logic [CREDIT_W-1:0] low;
        logic [CREDIT_W-1:0] high;
        logic [CREDIT_W-1:0] credit;
        logic                bp;
    } pair_state_t;

    pair_state_t st_d, st_q;
    logic [CREDIT_W:0] sum;

    always_comb begin
        st_d = st_q;
        sum  = '0;
        if (wr_low)  st_d.low  = wr_data[CREDIT_W-1:0];
        if (wr_high) st_d.high = wr_data[CREDIT_W-1:0];

        if (wr_alloc && wr_data[FORCE_BIT]) begin
            st_d.credit = wr_data[CREDIT_W-1:0];
        end else begin
            sum = {1'b0, st_q.credit};
            if (wr_alloc) sum = sum + {1'b0, wr_data[CREDIT_W-1:0]};
            if (consume && sum != '0) sum = sum - 1'b1;
            st_d.credit = sum[CREDIT_W] ? CREDIT_MAX : sum[CREDIT_W-1:0];
        end

        if (!enable)                    st_d.bp = 1'b0;
        else if (st_d.credit < st_q.low)  st_d.bp = 1'b1;
        else if (st_d.credit >= st_q.high) st_d.bp = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign low_mark  = st_q.low;
    assign high_mark = st_q.high;
    assign credit    = st_q.credit;
    assign bp        = st_q.bp;

    p_force_load_r5: assert property (@(posedge clk) disable iff (!rst_n)
        wr_alloc && wr_data[FORCE_BIT] |=> credit == $past(wr_data[CREDIT_W-1:0]));

    p_consume_dec_r6: assert property (@(posedge clk) disable iff (!rst_n)
        consume && !wr_alloc && credit != '0 |=> credit == $past(credit) - 1'b1);

    p_floor_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
        consume && !wr_alloc && credit == '0 |=> credit == '0);

    p_bp_assert_r7: assert property (@(posedge clk) disable iff (!rst_n)
        enable && st_d.credit < low_mark |=> bp);

    p_bp_release_r8: assert property (@(posedge clk) disable iff (!rst_n)
        enable && st_d.credit >= high_mark && st_d.credit >= low_mark |=> !bp);

    p_bp_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        enable && st_d.credit >= low_mark && st_d.credit < high_mark |=> bp == $past(bp));

endmodule

// File: rtl/flowc_credit_tracker.sv
module flowc_credit_tracker
    import flowc_pkg::*;
#(
    parameter int unsigned N_PAIRS  = 4,
    parameter int unsigned CREDIT_W = 8,
    parameter int unsigned ADDR_W   = 8,
    localparam int unsigned PAIR_W  = (N_PAIRS > 1) ? $clog2(N_PAIRS) : 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en,
    input  logic [ADDR_W-1:0]  wr_addr,
    input  logic [31:0]        wr_data,
    input  logic [ADDR_W-1:0]  rd_addr,
    output logic [31:0]        rd_data,
    input  logic [N_PAIRS-1:0] consume,
    output logic [N_PAIRS-1:0] backpressure
);

    localparam logic [3:0] CHAN_COUNT = 4'(2 * N_PAIRS);

    typedef struct packed {
        logic               glob;
        logic [N_PAIRS-1:0] en;
    } cfg_t;

    cfg_t cfg_d, cfg_q;

    reg_sel_e          wsel, rsel;
    logic [PAIR_W-1:0] wpair, rpair;

    logic [CREDIT_W-1:0] low_v  [N_PAIRS];
    logic [CREDIT_W-1:0] high_v [N_PAIRS];
    logic [CREDIT_W-1:0] cred_v [N_PAIRS];

    flowc_decode #(.N_PAIRS(N_PAIRS), .ADDR_W(ADDR_W)) u_wdec (
        .addr(wr_addr), .sel(wsel), .pair(wpair)
    );

    flowc_decode #(.N_PAIRS(N_PAIRS), .ADDR_W(ADDR_W)) u_rdec (
        .addr(rd_addr), .sel(rsel), .pair(rpair)
    );

    always_comb begin
        cfg_d = cfg_q;
        if (wr_en && wsel == SEL_CFG) begin
            cfg_d.glob = wr_data[0];
            cfg_d.en   = wr_data[N_PAIRS:1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cfg_q <= '0;
        else        cfg_q <= cfg_d;
    end

    for (genvar p = 0; p < N_PAIRS; p++) begin : g_pair
        logic hit;
        assign hit = wr_en && (wpair == PAIR_W'(p));

        flowc_pair #(.CREDIT_W(CREDIT_W)) u_pair (
            .clk      (clk),
            .rst_n    (rst_n),
            .enable   (cfg_q.glob & cfg_q.en[p]),
            .wr_low   (hit && wsel == SEL_LOW),
            .wr_high  (hit && wsel == SEL_HIGH),
            .wr_alloc (hit && wsel == SEL_ALLOC),
            .wr_data  (wr_data),
            .consume  (consume[p]),
            .low_mark (low_v[p]),
            .high_mark(high_v[p]),
            .credit   (cred_v[p]),
            .bp       (backpressure[p])
        );
    end

    always_comb begin
        rd_data = '0;
        case (rsel)
            SEL_CFG: begin
                rd_data[0]                       = cfg_q.glob;
                rd_data[N_PAIRS:1]               = cfg_q.en;
                rd_data[COUNT_LSB+3:COUNT_LSB]   = CHAN_COUNT;
            end
            SEL_LOW:   rd_data = 32'(low_v[rpair]);
            SEL_HIGH:  rd_data = 32'(high_v[rpair]);
            SEL_ALLOC: rd_data = 32'(cred_v[rpair]);
            default:   rd_data = '0;
        endcase
    end

    p_gate_global_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_q.glob |=> backpressure == '0);

    p_unmapped_write_r10: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en && wsel == SEL_NONE && consume == '0 |=> $stable(cfg_q));

    p_unmapped_read_r10: assert property (@(posedge clk) disable iff (!rst_n)
        rsel == SEL_NONE |-> rd_data == '0);

endmodule

// File: tb/tb_flowc_credit_tracker.sv
`timescale 1ns/1ps
module tb_flowc_credit_tracker;

    localparam int NP = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [7:0]  wr_addr = '0;
    logic [31:0] wr_data = '0;
    logic [7:0]  rd_addr = '0;
    logic [31:0] rd_data;
    logic [NP-1:0] consume = '0;
    logic [NP-1:0] backpressure;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    int  mc [NP];
    int  ml [NP];
    int  mh [NP];
    bit  mb [NP];
    bit  mg;
    bit [NP-1:0] me;

    always #2 clk = ~clk;

    flowc_credit_tracker dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
        .consume(consume), .backpressure(backpressure)
    );

    function automatic int a_low(int p);   return 4 + 12 * p;  endfunction
    function automatic int a_high(int p);  return 8 + 12 * p;  endfunction
    function automatic int a_alloc(int p); return 12 + 12 * p; endfunction

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic check_read(string req, int a, logic [31:0] exp);
        rd_addr = 8'(a);
        #0.1;
        check(req, rd_data, exp);
    endtask

    task automatic check_bp(string req);
        logic [NP-1:0] e;
        for (int p = 0; p < NP; p++) e[p] = mb[p];
        check(req, 32'(backpressure), 32'(e));
    endtask

    // Model of one clock edge: counts and flags use the pre-write marks/enables.
    task automatic model(bit we, int a, logic [31:0] d, logic [NP-1:0] cons);
        for (int p = 0; p < NP; p++) begin
            int s;
            if (we && a == a_alloc(p) && d[31]) s = int'(d[7:0]);
            else begin
                s = mc[p] + ((we && a == a_alloc(p)) ? int'(d[7:0]) : 0);
                if (cons[p] && s > 0) s--;
                if (s > 255) s = 255;
            end
            mc[p] = s;
            if (!(mg && me[p]))  mb[p] = 0;
            else if (s < ml[p])  mb[p] = 1;
            else if (s >= mh[p]) mb[p] = 0;
        end
        if (we) begin
            if (a == 0) begin mg = d[0]; me = d[NP:1]; end
            for (int p = 0; p < NP; p++) begin
                if (a == a_low(p))  ml[p] = int'(d[7:0]);
                if (a == a_high(p)) mh[p] = int'(d[7:0]);
            end
        end
    endtask

    task automatic cyc(bit we, int a, logic [31:0] d, logic [NP-1:0] cons);
        @(negedge clk);
        wr_en = we; wr_addr = 8'(a); wr_data = d; consume = cons;
        @(posedge clk);
        model(we, a, d, cons);
        #1;
        wr_en = 0; consume = '0;
    endtask

    function automatic logic [31:0] cfg_exp();
        logic [31:0] v = 32'h0800_0000;
        v[0] = mg;
        v[NP:1] = me;
        return v;
    endfunction

    initial begin
        #(4ns * 200000);
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog expired");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [15:0] lf = 16'hACE1;
        for (int p = 0; p < NP; p++) begin mc[p] = 0; ml[p] = 0; mh[p] = 0; mb[p] = 0; end
        mg = 0; me = '0;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;

        // R1 reset state
        check("R1 bp", 32'(backpressure), 0);
        check_read("R1 cfg", 0, 32'h0800_0000);
        for (int p = 0; p < NP; p++) begin
            check_read("R1 credit", a_alloc(p), 0);
            check_read("R1 low", a_low(p), 0);
            check_read("R1 high", a_high(p), 0);
        end

        // R2 mark programming, upper bits dropped
        for (int p = 0; p < NP; p++) begin
            cyc(1, a_low(p),  32'hFFFF_FF00 | 32'(p + 2), '0);
            cyc(1, a_high(p), 32'h1234_5600 | 32'(p + 5), '0);
        end
        for (int p = 0; p < NP; p++) begin
            check_read("R2 low", a_low(p), 32'(ml[p]));
            check_read("R2 high", a_high(p), 32'(mh[p]));
        end

        // R3 enable, count field read-only
        cyc(1, 0, 32'h0F00_001F, '0);
        check_read("R3 cfg", 0, cfg_exp());
        check("R3 cfg expected", cfg_exp(), 32'h0800_001F);

        // R7 empty pools raise backpressure
        cyc(0, 0, 0, '0);
        check_bp("R7 empty");

        // R4/R5/R6/R7/R8 sweep
        for (int i = 0; i < 1500; i++) begin
            int op, p;
            logic [31:0] d;
            lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
            op = int'(lf[2:0]);
            p  = int'(lf[4:3]);
            if (op < 4)       cyc(1, a_alloc(p), 32'(lf[6:5]), lf[14:11]);
            else if (op == 4) cyc(1, a_alloc(p), 32'h8000_0000 | 32'(lf[10:7]), lf[14:11]);
            else              cyc(0, 0, 0, lf[14:11]);
            check_bp("R7 R8 sweep bp");
            check_read("R4 R6 sweep credit", a_alloc(i % NP), 32'(mc[i % NP]));
        end

        // R4 saturation at top
        cyc(1, a_alloc(1), 32'h8000_00FA, '0);
        cyc(1, a_alloc(1), 32'd10, '0);
        check_read("R4 saturate", a_alloc(1), 32'd255);
        check_bp("R8 released high");

        // R5 force wins over consume
        cyc(1, a_alloc(1), 32'h8000_0007, 4'b0010);
        check_read("R5 force vs consume", a_alloc(1), 32'd7);

        // R6 floor at zero, net add and consume
        cyc(1, a_alloc(2), 32'h8000_0000, '0);
        cyc(0, 0, 0, 4'b0100);
        check_read("R6 floor", a_alloc(2), 32'd0);
        cyc(1, a_alloc(2), 32'd3, 4'b0100);
        check_read("R6 net", a_alloc(2), 32'd2);
        check("R6 model", 32'(mc[2]), 32'd2);

        // R8 hold between marks (pair 0: low 2, high 5)
        cyc(1, a_alloc(0), 32'h8000_0000, '0);
        check_bp("R7 below low");
        cyc(1, a_alloc(0), 32'd3, '0);
        check("R8 hold set", 32'(backpressure[0]), 1);
        cyc(1, a_alloc(0), 32'd2, '0);
        check("R8 release", 32'(backpressure[0]), 0);
        cyc(0, 0, 0, 4'b0001);
        cyc(0, 0, 0, 4'b0001);
        check("R8 hold clear", 32'(backpressure[0]), 0);

        // R9 pair and global gating
        cyc(1, a_alloc(3), 32'h8000_0000, '0);
        cyc(1, 0, 32'h0000_000F, '0);
        cyc(0, 0, 0, '0);
        check("R9 pair gated", 32'(backpressure[3]), 0);
        check_bp("R9 pair gated all");
        cyc(1, 0, 32'h0000_001E, '0);
        cyc(0, 0, 0, '0);
        check("R9 global gated", 32'(backpressure), 0);

        // R10 unmapped accesses
        cyc(1, 0, 32'h0000_001F, '0);
        cyc(1, 8'h40, 32'h8000_0055, '0);
        cyc(1, 8'h05, 32'h8000_0055, '0);
        cyc(1, 8'h0D, 32'h0000_0011, '0);
        check_read("R10 read 0x40", 8'h40, 0);
        check_read("R10 read 0x06", 8'h06, 0);
        check_read("R10 cfg kept", 0, cfg_exp());
        for (int p = 0; p < NP; p++) begin
            check_read("R10 credit kept", a_alloc(p), 32'(mc[p]));
            check_read("R10 low kept", a_low(p), 32'(ml[p]));
        end
        check_bp("R10 bp");

        done = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule